// File: doc/BRIEF.md
# Start-Busy-End Completion Monitor

This block watches a bracketed operation. A window opens when `start_i` is high. It stays alive through any number of cycles with `busy_i` high and closes when `end_i` rises in some later cycle. A window that closes this way places an obligation on the design under watch. `success_i` must be high in the same cycle as the closing `end_i`, and `done_i` must be high in the next cycle. When abort qualification is enabled, an `abort_i` pulse anywhere in the span from start to end, including both edge cycles, removes the obligation.

The monitor is synthesizable and sits next to the logic it observes. Each violation produces a one-cycle `fail_o`, and a sticky `error_o` records that a violation occurred. A saturating counter reports how many obligations have been fully evaluated. It does not check that `end_i` ever arrives.

Top module: `bsem_monitor`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `fail_o` is 0, `error_o` is 0 and `chk_cnt_o` is 0.
- R2: A window can close as early as the cycle directly after `start_i`. If `success_i` is high in that end cycle and `done_i` is high in the next cycle, `fail_o` stays low.
- R3: A window stays open across any number of intermediate cycles in which `busy_i` is high.
- R4: When a valid window closes and `success_i` is low in that end cycle, `fail_o` is high in that same cycle.
- R5: When `done_i` is low in the cycle after a valid end cycle, `fail_o` is high in that cycle.
- R6: If `busy_i` is low in any cycle strictly between start and end, the window is dropped without error, and a later `end_i` creates no obligation from that window.
- R7: With `ABORT_EN`=1, a window in which `abort_i` was high in any cycle from start through end, both inclusive, creates no obligation. With `ABORT_EN`=0, `abort_i` has no effect.
- R8: `error_o` goes high in the cycle after any cycle with `fail_o` high. It then stays high until reset.
- R9: Each closed valid window adds one to `chk_cnt_o`. The new value is visible from the second cycle after the end cycle. The counter saturates at 2^`CNT_W`-1.
- R10: When an end cycle coincides with the done-check cycle of an earlier window, the success check and the done check are evaluated independently. Either one can raise `fail_o`.
- R11: `start_i` in the same cycle as `end_i` does not close its own window. A `start_i` in a cycle where `busy_i` is low opens a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a window |
| busy_i | input | 1 | Keeps an open window alive |
| end_i | input | 1 | Closes an open window |
| abort_i | input | 1 | Disqualifies the window when `ABORT_EN`=1 |
| success_i | input | 1 | Must be high in the end cycle |
| done_i | input | 1 | Must be high in the cycle after the end cycle |
| fail_o | output | 1 | One-cycle violation pulse |
| error_o | output | 1 | Sticky violation flag |
| chk_cnt_o | output | CNT_W | Saturating count of evaluated obligations |

## Verification
The assertions take the observed inputs as free. They only assume that the inputs are known, non-X values from the first clock edge, because every property reasons about past input values.

The stimulus drives all six inputs to 0 from time zero. It changes them only at the falling clock edge. It mixes good, failing, dropped, aborted and overlapping windows, so every property's trigger fires while its antecedents stay defined.

// File: rtl/bsem_pkg.sv
package bsem_pkg;
  typedef struct packed {
    logic miss_succ;
    logic miss_done;
    logic chk_done;
  } oblig_t;
endpackage

// File: rtl/bsem_window.sv
module bsem_window #(
  parameter bit ABORT_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  input  logic end_i,
  input  logic abort_i,
  output logic hit_o
);
  logic armed_q, armed_d, qual_ok;

  generate
    if (ABORT_EN) begin : g_abort
      assign qual_ok = ~abort_i;
    end else begin : g_no_abort
      assign qual_ok = 1'b1;
    end
  endgenerate

  // a later start inside a live window spans a subset of it: one flag suffices
  assign armed_d = qual_ok & (start_i | (armed_q & busy_i));
  assign hit_o   = armed_q & end_i & qual_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  p_arm_from_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(start_i));

  p_drop_on_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !busy_i && !start_i) |=> !armed_q);

  generate
    if (ABORT_EN) begin : g_abort_chk
      p_abort_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |-> !hit_o);
    end
  endgenerate
endmodule

// File: rtl/bsem_oblig.sv
module bsem_oblig
  import bsem_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   hit_i,
  input  logic   end_i,
  input  logic   success_i,
  input  logic   done_i,
  output oblig_t res_o
);
  logic done_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_pend_q <= 1'b0;
    else         done_pend_q <= hit_i;
  end

  // success and done checks are independent, so they can fire in the same cycle
  assign res_o.miss_succ = hit_i & ~success_i;
  assign res_o.miss_done = done_pend_q & ~done_i;
  assign res_o.chk_done  = done_pend_q;

  p_done_follows_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pend_q |-> $past(end_i));

  p_fail_has_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o.miss_succ |-> (end_i && !success_i));
endmodule

// File: rtl/bsem_status.sv
module bsem_status #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fail_i,
  input  logic             chk_i,
  output logic             error_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic             error_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      error_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (fail_i) error_q <= 1'b1;
      if (chk_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign error_o = error_q;
  assign cnt_o   = cnt_q;

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_q |=> error_q);

  p_fail_sets_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> error_q);

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/bsem_monitor.sv
module bsem_monitor
  import bsem_pkg::*;
#(
  parameter bit ABORT_EN = 1'b1,
  parameter int CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             end_i,
  input  logic             abort_i,
  input  logic             success_i,
  input  logic             done_i,
  output logic             fail_o,
  output logic             error_o,
  output logic [CNT_W-1:0] chk_cnt_o
);
  logic   hit;
  oblig_t res;

  bsem_window #(.ABORT_EN(ABORT_EN)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy_i),
    .end_i(end_i), .abort_i(abort_i), .hit_o(hit)
  );

  bsem_oblig u_oblig (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .end_i(end_i),
    .success_i(success_i), .done_i(done_i), .res_o(res)
  );

  assign fail_o = res.miss_succ | res.miss_done;

  bsem_status #(.CNT_W(CNT_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .fail_i(fail_o), .chk_i(res.chk_done),
    .error_o(error_o), .cnt_o(chk_cnt_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!error_o && chk_cnt_o == '0));
endmodule

// File: tb/bsem_monitor_bench.sv
module bsem_monitor_bench;
  localparam int CNT_W = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 1'b0, bz = 1'b0, en = 1'b0, ab = 1'b0, su = 1'b0, dn = 1'b0;
  logic fail_a, err_a, fail_b, err_b;
  logic [CNT_W-1:0] cnt_a, cnt_b;

  always #10 clk = ~clk;

  bsem_monitor #(.ABORT_EN(1'b1), .CNT_W(CNT_W)) u_bsem_monitor (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st), .busy_i(bz), .end_i(en),
    .abort_i(ab), .success_i(su), .done_i(dn),
    .fail_o(fail_a), .error_o(err_a), .chk_cnt_o(cnt_a)
  );

  bsem_monitor #(.ABORT_EN(1'b0), .CNT_W(CNT_W)) u_bsem_monitor_noab (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st), .busy_i(bz), .end_i(en),
    .abort_i(ab), .success_i(su), .done_i(dn),
    .fail_o(fail_b), .error_o(err_b), .chk_cnt_o(cnt_b)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  // model state: one queue entry per open window, holding "abort seen"
  bit qa[$], qb[$];
  bit pa = 0, pb = 0, ea = 0, eb = 0;
  int ca = 0, cb = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit ab_en, ref bit q[$], ref bit pend, ref bit err,
                       ref int cnt, input string tag, input logic f, input logic e,
                       input logic [CNT_W-1:0] c);
    bit trig = 0;
    bit nq[$];
    bit exp_fail;
    foreach (q[k]) begin
      bit seen = q[k] | (ab_en & ab);
      if (en && !seen) trig = 1;
      if (bz) nq.push_back(seen);
    end
    if (st) nq.push_back(ab_en & ab);
    exp_fail = (trig && !su) || (pend && !dn);
    chk(tag, "fail_o", int'(f), int'(exp_fail));
    chk(tag, "error_o", int'(e), int'(err));
    chk(tag, "chk_cnt_o", int'(c), cnt);
    if (exp_fail) err = 1;
    if (pend && cnt < CMAX) cnt++;
    pend = trig;
    q = nq;
  endtask

  task automatic cyc(string tag, bit s, bit b, bit e, bit sc, bit d, bit a);
    st = s; bz = b; en = e; su = sc; dn = d; ab = a;
    #5;
    model(1'b1, qa, pa, ea, ca, tag, fail_a, err_a, cnt_a);
    model(1'b0, qb, pb, eb, cb, tag, fail_b, err_b, cnt_b);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    st = 0; bz = 0; en = 0; su = 0; dn = 0; ab = 0;
    rst_n = 1'b0;
    qa.delete(); qb.delete();
    pa = 0; pb = 0; ea = 0; eb = 0; ca = 0; cb = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "fail_o in reset", int'(fail_a | fail_b), 0);
    chk("R1", "error_o in reset", int'(err_a | err_b), 0);
    chk("R1", "chk_cnt_o in reset", int'(cnt_a) + int'(cnt_b), 0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    idle("R1", 2);
    // R2: shortest window, all good
    cyc("R2", 1, 0, 0, 0, 0, 0); cyc("R2", 0, 0, 1, 1, 0, 0);
    cyc("R2", 0, 0, 0, 0, 1, 0); idle("R2", 2);
    chk("R2", "count after good window", int'(cnt_a), 1);
    // R3: long busy stretch
    cyc("R3", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R3", 0, 1, 0, 0, 0, 0);
    cyc("R3", 0, 0, 1, 1, 0, 0); cyc("R3", 0, 0, 0, 0, 1, 0); idle("R3", 2);
    // R4: success missing
    cyc("R4", 1, 0, 0, 0, 0, 0); cyc("R4", 0, 1, 0, 0, 0, 0);
    cyc("R4", 0, 0, 1, 0, 0, 0); cyc("R4", 0, 0, 0, 0, 1, 0); idle("R4", 2);
    // R5: done missing
    cyc("R5", 1, 0, 0, 0, 0, 0); cyc("R5", 0, 0, 1, 1, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0); idle("R5", 2);
    // R8: sticky error survives idle
    idle("R8", 3);
    chk("R8", "error_o sticky", int'(err_a), 1);
    do_reset();
    chk("R8", "error_o cleared by reset", int'(err_a), 0);
    // R6: busy gap drops the window
    cyc("R6", 1, 0, 0, 0, 0, 0); cyc("R6", 0, 1, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0); cyc("R6", 0, 0, 1, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0); idle("R6", 2);
    chk("R6", "no error after dropped window", int'(err_a | err_b), 0);
    // R7: abort mid-window, then abort only in end cycle, then only in start cycle
    cyc("R7", 1, 0, 0, 0, 0, 0); cyc("R7", 0, 1, 0, 0, 0, 1);
    cyc("R7", 0, 1, 0, 0, 0, 0); cyc("R7", 0, 0, 1, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0); idle("R7", 2);
    chk("R7", "abort qualified no error", int'(err_a), 0);
    chk("R7", "unqualified instance flags", int'(err_b), 1);
    cyc("R7", 1, 0, 0, 0, 0, 0); cyc("R7", 0, 0, 1, 0, 0, 1);
    cyc("R7", 0, 0, 0, 0, 0, 0); idle("R7", 2);
    cyc("R7", 1, 0, 0, 0, 0, 1); cyc("R7", 0, 0, 1, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0); idle("R7", 2);
    chk("R7", "abort at edges no error", int'(err_a), 0);
    // R11: start with end in same cycle does not close itself
    do_reset();
    cyc("R11", 1, 0, 1, 0, 0, 0); cyc("R11", 0, 0, 0, 0, 0, 0); idle("R11", 2);
    chk("R11", "self close ignored", int'(err_a), 0);
    // R11: start while busy low re-arms
    cyc("R11", 1, 0, 0, 0, 0, 0); cyc("R11", 1, 0, 0, 0, 0, 0);
    cyc("R11", 0, 0, 1, 0, 0, 0); cyc("R11", 0, 0, 0, 0, 1, 0); idle("R11", 2);
    chk("R11", "re-armed window checked", int'(err_a), 1);
    // R10: second end coincides with first done check
    do_reset();
    cyc("R10", 1, 0, 0, 0, 0, 0); cyc("R10", 1, 0, 1, 1, 0, 0);
    cyc("R10", 0, 0, 1, 1, 1, 0); cyc("R10", 0, 0, 0, 0, 0, 0); idle("R10", 2);
    cyc("R10", 1, 0, 0, 0, 0, 0); cyc("R10", 1, 0, 1, 1, 0, 0);
    cyc("R10", 0, 0, 1, 0, 0, 0); cyc("R10", 0, 0, 0, 0, 1, 0); idle("R10", 2);
    // R9: count saturation
    do_reset();
    for (int i = 0; i < CMAX + 2; i++) begin
      cyc("R9", 1, 0, 0, 0, 0, 0); cyc("R9", 0, 0, 1, 1, 0, 0);
      cyc("R9", 0, 0, 0, 0, 1, 0);
    end
    idle("R9", 2);
    chk("R9", "count saturated", int'(cnt_a), CMAX);
    finish_run();
  end
endmodule